// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between a memory port whose response time varies and an in-order processor pipeline. It retimes every load so that its result reaches writeback a fixed, software-chosen number of cycles after the load was issued. Software writes the latency it planned its code around into a small latency register. A response that comes back early is parked in a slot until its due cycle. A response that is still missing at its due cycle holds the pipeline with a stall output until it arrives.

Each accepted load takes one of eight slots. The slot records the load's tag and a countdown of the cycles left until it is due. Responses find their slot by tag, and the buffer writes back at most one load per cycle. All loads share one latency and are accepted at most one per cycle, so no two slots ever fall due together. While the pipeline is stalled, every countdown is held, so the loads behind the late one keep their spacing.

Top module: `fixed_latency_load_buffer`

## Requirements
- R1: The latency register is 5 bits wide and resets to 4. A write of any value from 1 to 31 replaces it. A write of 0 is ignored.
- R2: A latency write is accepted only in a cycle that begins with no load outstanding, and is ignored otherwise. A load accepted in the same cycle as an accepted write uses the previous latency.
- R3: A load accepted in cycle c (ld_valid and ld_ready both high) while latency L is in force is written back in cycle c+L, provided its response arrived in cycles c+1 to c+L. A response in cycle c+L is forwarded to writeback in that same cycle.
- R4: If a load's response has not arrived by its due cycle, stall is high from that cycle until the cycle in which the response arrives. In that cycle stall is low and the load is written back.
- R5: In every cycle with stall high, the countdowns of all other outstanding loads are held. Each of those loads is therefore written back one cycle later for every stall cycle.
- R6: At most one load is written back per cycle. wb_tag and wb_data carry the tag the load was issued with and the data of its first matching response. wb_valid and stall are never high together.
- R7: At most 8 loads are outstanding. ld_ready is low whenever all 8 slots are occupied or stall is high, and a load presented while ld_ready is low is not accepted.
- R8: A response whose tag matches no outstanding load that still lacks data is ignored. This covers unknown tags, repeats of a tag whose data is already held, and a response for a load accepted in that same cycle. An ignored response changes no written-back value or timing.
- R9: After reset, no load is outstanding, wb_valid and stall are low and ld_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_we | input | 1 | Latency register write strobe |
| lat_wdata | input | 5 | New latency value |
| ld_valid | input | 1 | A load is being issued this cycle |
| ld_tag | input | 4 | Tag of the issued load, unique among outstanding loads |
| ld_ready | output | 1 | The buffer can accept a load this cycle |
| rsp_valid | input | 1 | Memory returns data this cycle |
| rsp_tag | input | 4 | Tag of the returned data |
| rsp_data | input | 32 | Returned load data |
| wb_valid | output | 1 | A load completes to the pipeline this cycle |
| wb_tag | output | 4 | Tag of the completing load |
| wb_data | output | 32 | Data of the completing load |
| stall | output | 1 | The due load has no data yet; the pipeline must hold |

## Verification
Two things can happen in the same cycle: a memory response arrives for the very load that falls due, and writeback of that load. The response must then be forwarded straight to writeback, with no stall. The bench provokes this with responses scheduled exactly at the due cycle, and also one cycle late. In the late case the stall must last exactly until the response cycle, and the loads queued behind it must slide by the same number of cycles. A behavioural model judges every cycle, comparing wb_valid, wb_tag, wb_data, stall and ld_ready against values computed from per-load countdowns.

// File: rtl/flb_pkg.sv
// Shared types for the fixed-latency load buffer.
// Assumes: nothing beyond the parameters of the users of this package.
package flb_pkg;

    localparam int LAT_W_DEF = 5;

    // Per-slot status seen by the top level
    typedef struct packed {
        logic busy;    // slot holds an outstanding load
        logic due;     // countdown has reached zero
        logic have;    // data captured earlier
        logic hit;     // current response targets this slot
        logic retire;  // slot completes to writeback this cycle
    } slot_flags_t;

endpackage

// File: rtl/flb_latreg.sv
// Latency register: holds the programmed load-to-use latency.
// Assumes: idle_i is high only when no slot is occupied.
module flb_latreg #(
    parameter int LAT_W   = 5,
    parameter int LAT_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [LAT_W-1:0] wdata_i,
    input  logic             idle_i,
    output logic [LAT_W-1:0] lat_o
);

    logic [LAT_W-1:0] lat_q;

    // Accept a non-zero write only while the buffer is empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= LAT_W'(LAT_RST);
        else if (we_i && idle_i && (wdata_i != '0))
            lat_q <= wdata_i;
    end

    assign lat_o = lat_q;

    assert_lat_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q != '0);

    assert_lat_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(lat_q));

endmodule

// File: rtl/flb_slot.sv
// One buffer slot: keeps a load's tag, its captured data and a countdown to
// its due cycle, and reports whether it completes or stalls this cycle.
// Assumes: alloc_i only targets a free slot; tags are unique among slots.
module flb_slot
    import flb_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [TAG_W-1:0]  alloc_tag_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              freeze_i,
    output slot_flags_t       flags_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o
);

    logic              busy_q;
    logic              have_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic [LAT_W-1:0]  cnt_q;
    logic              hit;
    logic              due;
    logic              retire;

    // Decode this slot's view of the current cycle
    always_comb begin
        hit    = busy_q && !have_q && rsp_valid_i && (rsp_tag_i == tag_q);
        due    = busy_q && (cnt_q == '0);
        retire = due && (have_q || hit);
    end

    // Allocate, capture data, count down, release on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            have_q <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            have_q <= 1'b0;
            tag_q  <= alloc_tag_i;
            cnt_q  <= lat_i - 1'b1;
        end else if (retire) begin
            busy_q <= 1'b0;
            have_q <= 1'b0;
        end else begin
            if (hit) begin
                have_q <= 1'b1;
                data_q <= rsp_data_i;
            end
            if (busy_q && (cnt_q != '0) && !freeze_i)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign flags_o = '{busy: busy_q, due: due, have: have_q, hit: hit, retire: retire};
    assign tag_o   = tag_q;
    assign data_o  = have_q ? data_q : rsp_data_i;   // forward a due-cycle response

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !have_q && !hit) |=> (busy_q && (cnt_q == '0)));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !due && freeze_i && !alloc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/flb_pick.sv
// Free-slot picker: grants the lowest-numbered free slot.
// Assumes: the caller qualifies the grant with its own accept condition.
module flb_pick #(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] free_i,
    output logic [NUM_SLOTS-1:0] grant_o
);

    // Priority scan from slot 0 upward
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (free_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fixed_latency_load_buffer.sv
// Fixed-latency load return buffer: accepts tagged loads, matches memory
// responses by tag and releases each load exactly the programmed latency
// after issue, stalling the pipeline while a due load has no data.
// Assumes: at most one issue per cycle, unique tags among outstanding loads,
// and every issued load eventually receives a response.
module fixed_latency_load_buffer
    import flb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 32,
    parameter int LAT_W     = LAT_W_DEF,
    parameter int LAT_RST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_we,
    input  logic [LAT_W-1:0]  lat_wdata,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    output logic              ld_ready,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);

    localparam logic [NUM_SLOTS-1:0] ALL_BUSY = {NUM_SLOTS{1'b1}};

    slot_flags_t       flags    [NUM_SLOTS];
    logic [TAG_W-1:0]  slot_tag [NUM_SLOTS];
    logic [DATA_W-1:0] slot_data[NUM_SLOTS];
    logic [NUM_SLOTS-1:0] busy_vec, due_vec, wait_vec, retire_vec, grant;
    logic [LAT_W-1:0]  lat;
    logic              issue_fire;

    flb_latreg #(.LAT_W(LAT_W), .LAT_RST(LAT_RST)) u_latreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lat_we),
        .wdata_i (lat_wdata),
        .idle_i  (busy_vec == '0),
        .lat_o   (lat)
    );

    flb_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .free_i  (~busy_vec),
        .grant_o (grant)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        flb_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (grant[i] && issue_fire),
            .alloc_tag_i (ld_tag),
            .lat_i       (lat),
            .rsp_valid_i (rsp_valid),
            .rsp_tag_i   (rsp_tag),
            .rsp_data_i  (rsp_data),
            .freeze_i    (stall),
            .flags_o     (flags[i]),
            .tag_o       (slot_tag[i]),
            .data_o      (slot_data[i])
        );
    end

    // Gather slot status into vectors
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            busy_vec[i]   = flags[i].busy;
            due_vec[i]    = flags[i].due;
            wait_vec[i]   = flags[i].due && !flags[i].have && !flags[i].hit;
            retire_vec[i] = flags[i].retire;
        end
    end

    // Stall and issue acceptance
    always_comb begin
        stall      = |wait_vec;
        ld_ready   = (busy_vec != ALL_BUSY) && !stall;
        issue_fire = ld_valid && ld_ready;
    end

    // Writeback mux: at most one slot retires per cycle
    always_comb begin
        wb_valid = |retire_vec;
        wb_tag   = '0;
        wb_data  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (retire_vec[i]) begin
                wb_tag  = wb_tag  | slot_tag[i];
                wb_data = wb_data | slot_data[i];
            end
        end
    end

    assert_one_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(due_vec));

    assert_wb_excl_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && stall));

    assert_full_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec == ALL_BUSY) |-> !ld_ready);

    assert_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=>
            ($countones(busy_vec) == $past($countones(busy_vec)) + 1 - int'($past(wb_valid))));

endmodule

// File: tb/fixed_latency_load_buffer_tb.sv
// Bench: behavioural per-load countdown model compared every cycle.
module fixed_latency_load_buffer_tb;

    localparam int TW = 4;
    localparam int DW = 32;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          lat_we = 0;
    logic [LW-1:0] lat_wdata = '0;
    logic          ld_valid = 0;
    logic [TW-1:0] ld_tag = '0;
    logic          ld_ready;
    logic          rsp_valid = 0;
    logic [TW-1:0] rsp_tag = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          wb_valid;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_data;
    logic          stall;

    fixed_latency_load_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .lat_wdata(lat_wdata),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_ready(ld_ready),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .stall(stall)
    );

    typedef struct packed {
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
        logic          have;
        logic [5:0]    rem;
    } ld_t;

    typedef struct packed {
        logic [TW-1:0] tag;
        int            at;
    } mr_t;

    ld_t   mq[$];
    mr_t   mem[$];
    int    lat_m = 4;
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";
    logic [TW-1:0] tagctr = '0;
    bit    issued;

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    // One cycle: compare outputs with the model, then advance the model
    task automatic tick();
        int  due_i, hit_i, nl;
        bit  e_wb, e_st, e_rdy, wr_ok;
        logic [TW-1:0] e_tag;
        logic [DW-1:0] e_dat;
        #1;
        due_i = -1; hit_i = -1; e_wb = 0; e_tag = '0; e_dat = '0;
        foreach (mq[k]) begin
            if (mq[k].rem == 0) due_i = k;
            if (rsp_valid && !mq[k].have && mq[k].tag == rsp_tag) hit_i = k;
        end
        if (due_i >= 0) begin
            e_wb  = mq[due_i].have || (hit_i == due_i);
            e_tag = mq[due_i].tag;
            e_dat = mq[due_i].have ? mq[due_i].data : rsp_data;
        end
        e_st  = (due_i >= 0) && !e_wb;
        e_rdy = (mq.size() < 8) && !e_st;
        chk(wb_valid === e_wb, "wb_valid", wb_valid, e_wb);
        chk(stall === e_st, "stall", stall, e_st);
        chk(ld_ready === e_rdy, "ld_ready", ld_ready, e_rdy);
        if (e_wb) begin
            chk(wb_tag === e_tag, "wb_tag", wb_tag, e_tag);
            chk(wb_data === e_dat, "wb_data", wb_data, e_dat);
        end
        wr_ok = lat_we && (mq.size() == 0) && (lat_wdata != 0);
        nl = wr_ok ? int'(lat_wdata) : lat_m;
        if (hit_i >= 0) begin
            mq[hit_i].have = 1'b1;
            mq[hit_i].data = rsp_data;
        end
        if (!e_st)
            foreach (mq[k]) if (mq[k].rem != 0) mq[k].rem = mq[k].rem - 1;
        if (e_wb) mq.delete(due_i);
        issued = ld_valid && e_rdy;
        if (issued) mq.push_back('{tag: ld_tag, data: '0, have: 1'b0, rem: 6'(lat_m - 1)});
        lat_m = nl;
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive the earliest scheduled memory response, if any is ready
    task automatic pick_mem();
        rsp_valid = 0;
        for (int k = 0; k < mem.size(); k++) begin
            if (mem[k].at <= cyc) begin
                rsp_valid = 1;
                rsp_tag   = mem[k].tag;
                rsp_data  = $urandom;
                mem.delete(k);
                break;
            end
        end
    endtask

    // A cycle with optional issue; the memory answers dly cycles later
    task automatic cyc_auto(bit go, int dly);
        int c0;
        c0 = cyc;
        pick_mem();
        ld_valid = go;
        ld_tag   = tagctr;
        tick();
        if (issued) begin
            mem.push_back('{tag: tagctr, at: c0 + dly});
            tagctr++;
        end
        ld_valid  = 0;
        rsp_valid = 0;
    endtask

    // A cycle carrying a hand-made response
    task automatic cyc_resp(logic [TW-1:0] t, logic [DW-1:0] d);
        rsp_valid = 1; rsp_tag = t; rsp_data = d; ld_valid = 0;
        tick();
        rsp_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc_auto(0, 0);
    endtask

    task automatic drain();
        for (int g = 0; g < 400 && (mq.size() != 0 || mem.size() != 0); g++) cyc_auto(0, 0);
    endtask

    task automatic set_lat(int v, bit go, int dly);
        lat_we = 1; lat_wdata = LW'(v);
        cyc_auto(go, dly);
        lat_we = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        cur_req = "R9";
        chk(wb_valid === 1'b0, "reset wb_valid", wb_valid, 0);
        chk(stall === 1'b0, "reset stall", stall, 0);
        chk(ld_ready === 1'b1, "reset ld_ready", ld_ready, 1);
        @(negedge clk);

        // R3: default latency 4, early and exact-due responses
        cur_req = "R3";
        cyc_auto(1, 2); idle(6);
        cyc_auto(1, 4); idle(6);
        cyc_auto(1, 1); cyc_auto(1, 4); cyc_auto(1, 3); drain();

        // R1: zero write ignored, then extremes 1 and 31
        cur_req = "R1";
        set_lat(0, 0, 0); cyc_auto(1, 3); drain();
        set_lat(1, 0, 0); cyc_auto(1, 1); cyc_auto(1, 1); drain();
        set_lat(31, 0, 0); cyc_auto(1, 20); drain();
        set_lat(3, 0, 0);

        // R2: write while busy ignored; write plus issue uses old latency
        cur_req = "R2";
        cyc_auto(1, 2); set_lat(9, 0, 0); drain();
        cyc_auto(1, 3); drain();
        set_lat(6, 1, 2); drain();
        cyc_auto(1, 6); drain();

        // R4 and R5: late response stalls, the following load slides
        cur_req = "R4";
        cyc_auto(1, 9); cyc_auto(0, 0); cyc_auto(1, 2); drain();
        cur_req = "R5";
        cyc_auto(1, 7); cyc_auto(1, 1); cyc_auto(1, 12); cyc_auto(1, 3); drain();

        // R7: long latency, back-to-back issue fills all slots
        cur_req = "R7";
        set_lat(12, 0, 0);
        for (int i = 0; i < 12; i++) cyc_auto(1, 5);
        drain();

        // R8: unknown tag, repeated tag, same-cycle response to a new load
        cur_req = "R8";
        set_lat(5, 0, 0);
        cyc_auto(1, 1);
        cyc_resp(tagctr + 4'd7, 32'hDEAD_BEEF);
        cyc_resp(tagctr - 4'd1, 32'h1234_5678);
        idle(4);
        rsp_valid = 1; rsp_tag = tagctr; rsp_data = 32'hCAFE_F00D;
        ld_valid = 1; ld_tag = tagctr; tick();
        ld_valid = 0; rsp_valid = 0;
        if (issued) begin mem.push_back('{tag: tagctr, at: cyc + 2}); tagctr++; end
        drain();

        // R6: a completion every cycle at short latency
        cur_req = "R6";
        set_lat(2, 0, 0);
        for (int i = 0; i < 20; i++) cyc_auto(1, (i % 2) + 1);
        drain();

        // Random traffic at several latencies, early and late responses
        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            int l;
            l = (s == 0) ? 2 : (s == 1) ? 5 : (s == 2) ? 9 : 14;
            set_lat(l, 0, 0);
            for (int i = 0; i < 700; i++)
                cyc_auto($urandom_range(0, 99) < 60, $urandom_range(1, l + 5));
            drain();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule